// File: doc/BRIEF.md
# Incrementing-Burst AHB Master

This block is a reduced AHB bus master. A user command names a start address, a direction, a single-or-burst choice, a beat count and a transfer size. The master turns that command into a train of AHB address phases, each followed one cycle later by its data phase. Write data comes in on a small valid/ready stream, one word per beat. Read data leaves on an output stream, one word per beat, in beat order.

The slave is assumed to insert no wait states and to answer OKAY on every beat, so the master advances once per clock and has no HREADY or HRESP input. Only incrementing bursts are issued. A command carries one direction and one transfer kind, so a change of direction, or a change between burst and single, needs a new command. A new command is accepted only after the previous command's last data phase has finished.

The command channel is valid/ready: a command is taken in any cycle where `cmd_valid` and `cmd_ready` are both high, and its fields are sampled only then. The write data channel has no back-pressure toward the master. `wdat_ready` rises in each write address phase, and the source must present valid data in that cycle. The read data channel has no ready signal, so the consumer must take every `rdat_valid` cycle.

Top module: `ahb_burst_master`

## Requirements
- R1: `cmd_ready` is high exactly when no transaction is in flight. A command is taken on `cmd_valid && cmd_ready`, and changes to the command inputs at any other time have no effect on the bus.
- R2: The first address phase comes in the cycle after acceptance, with HTRANS=NONSEQ (2'b10) and HADDR equal to the command address. The remaining beats follow in consecutive cycles with HTRANS=SEQ (2'b11). HTRANS is IDLE (2'b00) from the cycle after the last address phase onward.
- R3: Each SEQ beat's HADDR equals the previous beat's HADDR plus 1 << HSIZE.
- R4: HSIZE is the command size clamped to a word: 0 gives bytes, 1 gives halfwords, and any value of 2 or more gives 2 (word).
- R5: A single command issues exactly one beat with HBURST=3'b000, whatever the beat count. A burst with 4, 8 or 16 beats uses 3'b011, 3'b101 or 3'b111. Any other count uses 3'b001, and a count of 0 is taken as 1. Wrapping encodings (3'b010, 3'b100, 3'b110) never appear.
- R6: `wdat_ready` is high in each write address-phase cycle. The word present then is driven unchanged on HWDATA in the next cycle, which is that beat's data phase. Byte-lane placement is the source's job.
- R7: HRDATA sampled at the end of each read data phase appears on `rdat_data` with `rdat_valid` high in the following cycle, once per beat and in beat order.
- R8: `done` is a one-cycle pulse in the cycle after the final data phase. `cmd_ready` returns high in that same cycle.
- R9: HWRITE, HSIZE and HBURST stay constant across all beats of a command, and HWRITE equals the command's direction.
- R10: After reset HTRANS is IDLE, `cmd_ready` is 1, and `done`, `rdat_valid` and `wdat_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Master can take a command |
| cmd_addr | input | AW | Start byte address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_burst | input | 1 | 1 = incrementing burst, 0 = single |
| cmd_beats | input | BW | Burst beat count (0 taken as 1) |
| cmd_size | input | 3 | Requested transfer size, log2 bytes |
| wdat_valid | input | 1 | Write word present |
| wdat_ready | output | 1 | Write word taken this cycle |
| wdat_data | input | DW | Write word |
| rdat_valid | output | 1 | Read word valid |
| rdat_data | output | DW | Read word |
| done | output | 1 | Command completed pulse |
| haddr | output | AW | AHB address |
| htrans | output | 2 | AHB transfer type |
| hwrite | output | 1 | AHB direction |
| hsize | output | 3 | AHB transfer size |
| hburst | output | 3 | AHB burst type |
| hwdata | output | DW | AHB write data |
| hrdata | input | DW | AHB read data |

## Verification
The checks assume that the write source never leaves `wdat_valid` low while `wdat_ready` is high. They also assume that the slave side is zero-wait, so a data phase always ends one cycle after its address phase. The bench meets the first assumption by presenting each beat's word in the same cycle the master raises `wdat_ready`. It meets the second with a memory model that registers the address phase and serves or stores data in the next cycle, with no stall. Start addresses are aligned to the clamped size and kept inside the model's 256-byte window, so the incrementing addresses never wrap.

// File: rtl/ahb_mst_pkg.sv
package ahb_mst_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic [2:0] BU_SINGLE = 3'b000;
  localparam logic [2:0] BU_INCR   = 3'b001;
  localparam logic [2:0] BU_INCR4  = 3'b011;
  localparam logic [2:0] BU_INCR8  = 3'b101;
  localparam logic [2:0] BU_INCR16 = 3'b111;

  localparam logic [2:0] SZ_WORD = 3'd2;

  typedef struct packed {
    logic       write;
    logic [2:0] size;
    logic [2:0] burst;
  } xfer_attr_t;
endpackage

// File: rtl/ahb_mst_cmd_decode.sv
module ahb_mst_cmd_decode
  import ahb_mst_pkg::*;
#(
  parameter int BW = 5
) (
  input  logic          cmd_write,
  input  logic          cmd_burst,
  input  logic [BW-1:0] cmd_beats,
  input  logic [2:0]    cmd_size,
  output xfer_attr_t    attr,
  output logic [BW-1:0] beats_m1
);
  logic [BW-1:0] beats_eff;
  logic [2:0]    size_eff;
  logic [2:0]    burst_enc;

  always_comb begin
    size_eff = (cmd_size > SZ_WORD) ? SZ_WORD : cmd_size;
  end

  always_comb begin
    if (!cmd_burst) begin
      beats_eff = BW'(1);
      burst_enc = BU_SINGLE;
    end else begin
      beats_eff = (cmd_beats == '0) ? BW'(1) : cmd_beats;
      if (int'(beats_eff) == 4)       burst_enc = BU_INCR4;
      else if (int'(beats_eff) == 8)  burst_enc = BU_INCR8;
      else if (int'(beats_eff) == 16) burst_enc = BU_INCR16;
      else                            burst_enc = BU_INCR;
    end
  end

  assign beats_m1    = beats_eff - BW'(1);
  assign attr.write  = cmd_write;
  assign attr.size   = size_eff;
  assign attr.burst  = burst_enc;
endmodule

// File: rtl/ahb_mst_addr_seq.sv
module ahb_mst_addr_seq
  import ahb_mst_pkg::*;
#(
  parameter int AW = 32,
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  xfer_attr_t    attr_in,
  input  logic [AW-1:0] addr_in,
  input  logic [BW-1:0] beats_m1_in,
  output logic [AW-1:0] haddr,
  output trans_e        htrans,
  output xfer_attr_t    attr_q,
  output logic          busy,
  output logic          aphase_last
);
  logic          first_q;
  logic [BW-1:0] remain_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] step;

  assign step = AW'(1) << attr_q.size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      first_q  <= 1'b0;
      remain_q <= '0;
      addr_q   <= '0;
      attr_q   <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      first_q  <= 1'b1;
      remain_q <= beats_m1_in;
      addr_q   <= addr_in;
      attr_q   <= attr_in;
    end else if (busy) begin
      first_q <= 1'b0;
      if (remain_q == '0) begin
        busy <= 1'b0;
      end else begin
        remain_q <= remain_q - BW'(1);
        addr_q   <= addr_q + step;
      end
    end
  end

  always_comb begin
    if (!busy)        htrans = TR_IDLE;
    else if (first_q) htrans = TR_NONSEQ;
    else              htrans = TR_SEQ;
  end

  assign haddr       = addr_q;
  assign aphase_last = busy && (remain_q == '0);
endmodule

// File: rtl/ahb_mst_data_phase.sv
module ahb_mst_data_phase #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          aphase_valid,
  input  logic          aphase_write,
  input  logic          aphase_last,
  input  logic          wdat_valid,
  input  logic [DW-1:0] wdat_data,
  input  logic [DW-1:0] hrdata,
  output logic [DW-1:0] hwdata,
  output logic          rdat_valid,
  output logic [DW-1:0] rdat_data,
  output logic          done,
  output logic          dp_valid
);
  logic dp_write;
  logic dp_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid   <= 1'b0;
      dp_write   <= 1'b0;
      dp_last    <= 1'b0;
      hwdata     <= '0;
      rdat_valid <= 1'b0;
      rdat_data  <= '0;
      done       <= 1'b0;
    end else begin
      dp_valid   <= aphase_valid;
      dp_write   <= aphase_write;
      dp_last    <= aphase_last;
      if (aphase_valid && aphase_write && wdat_valid) hwdata <= wdat_data;
      rdat_valid <= dp_valid && !dp_write;
      if (dp_valid && !dp_write) rdat_data <= hrdata;
      done       <= dp_valid && dp_last;
    end
  end
endmodule

// File: rtl/ahb_burst_master.sv
module ahb_burst_master
  import ahb_mst_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic          cmd_write,
  input  logic          cmd_burst,
  input  logic [BW-1:0] cmd_beats,
  input  logic [2:0]    cmd_size,
  input  logic          wdat_valid,
  output logic          wdat_ready,
  input  logic [DW-1:0] wdat_data,
  output logic          rdat_valid,
  output logic [DW-1:0] rdat_data,
  output logic          done,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic          hwrite,
  output logic [2:0]    hsize,
  output logic [2:0]    hburst,
  output logic [DW-1:0] hwdata,
  input  logic [DW-1:0] hrdata
);
  xfer_attr_t    dec_attr;
  xfer_attr_t    cur_attr;
  logic [BW-1:0] dec_beats_m1;
  logic          busy;
  logic          aphase_last;
  logic          dp_valid;
  logic          start;
  trans_e        trans_q;

  assign cmd_ready = !busy && !dp_valid;
  assign start     = cmd_valid && cmd_ready;

  ahb_mst_cmd_decode #(.BW(BW)) u_dec (
    .cmd_write (cmd_write),
    .cmd_burst (cmd_burst),
    .cmd_beats (cmd_beats),
    .cmd_size  (cmd_size),
    .attr      (dec_attr),
    .beats_m1  (dec_beats_m1)
  );

  ahb_mst_addr_seq #(.AW(AW), .BW(BW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .attr_in     (dec_attr),
    .addr_in     (cmd_addr),
    .beats_m1_in (dec_beats_m1),
    .haddr       (haddr),
    .htrans      (trans_q),
    .attr_q      (cur_attr),
    .busy        (busy),
    .aphase_last (aphase_last)
  );

  ahb_mst_data_phase #(.DW(DW)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .aphase_valid (busy),
    .aphase_write (cur_attr.write),
    .aphase_last  (aphase_last),
    .wdat_valid   (wdat_valid),
    .wdat_data    (wdat_data),
    .hrdata       (hrdata),
    .hwdata       (hwdata),
    .rdat_valid   (rdat_valid),
    .rdat_data    (rdat_data),
    .done         (done),
    .dp_valid     (dp_valid)
  );

  assign htrans     = trans_q;
  assign hwrite     = cur_attr.write;
  assign hsize      = cur_attr.size;
  assign hburst     = cur_attr.burst;
  assign wdat_ready = busy && cur_attr.write;
endmodule

// File: rtl/ahb_burst_master_chk.sv
module ahb_burst_master_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [AW-1:0] haddr,
  input logic [1:0]    htrans,
  input logic          hwrite,
  input logic [2:0]    hsize,
  input logic [2:0]    hburst,
  input logic          wdat_valid,
  input logic          wdat_ready,
  input logic          rdat_valid,
  input logic          done
);
  // R4
  size_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != 2'b00) |-> (hsize <= 3'd2));

  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != 2'b00) |-> (hburst == 3'b000 || hburst[0]));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b11) |-> (haddr == $past(haddr) + (AW'(1) << hsize)));

  // R2
  seq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b11) |-> ($past(htrans) != 2'b00));

  // R2
  start_nonseq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (htrans == 2'b10));

  // R9
  attr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b11) |-> ($stable(hwrite) && $stable(hsize) && $stable(hburst)));

  // R1
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != 2'b00) |-> !cmd_ready);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_ready && htrans == 2'b00));

  // R6
  wdat_env_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdat_ready |-> wdat_valid);

  // R7
  rd_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdat_valid |-> !hwrite);
endmodule

bind ahb_burst_master ahb_burst_master_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .haddr      (haddr),
  .htrans     (htrans),
  .hwrite     (hwrite),
  .hsize      (hsize),
  .hburst     (hburst),
  .wdat_valid (wdat_valid),
  .wdat_ready (wdat_ready),
  .rdat_valid (rdat_valid),
  .done       (done)
);

// File: tb/ahb_burst_master_test.sv
module ahb_burst_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic          cmd_write = 1'b0;
  logic          cmd_burst = 1'b0;
  logic [BW-1:0] cmd_beats = '0;
  logic [2:0]    cmd_size = '0;
  logic          wdat_valid = 1'b0;
  logic          wdat_ready;
  logic [DW-1:0] wdat_data = '0;
  logic          rdat_valid;
  logic [DW-1:0] rdat_data;
  logic          done;
  logic [AW-1:0] haddr;
  logic [1:0]    htrans;
  logic          hwrite;
  logic [2:0]    hsize;
  logic [2:0]    hburst;
  logic [DW-1:0] hwdata;
  logic [DW-1:0] hrdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ahb_burst_master #(.AW(AW), .DW(DW), .BW(BW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_write(cmd_write), .cmd_burst(cmd_burst), .cmd_beats(cmd_beats),
    .cmd_size(cmd_size),
    .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_data(wdat_data),
    .rdat_valid(rdat_valid), .rdat_data(rdat_data), .done(done),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
    .hburst(hburst), .hwdata(hwdata), .hrdata(hrdata)
  );

  // Zero-wait memory slave, 256 bytes, little-endian lanes
  logic [7:0] mem [256];
  logic       m_v = 1'b0;
  logic       m_w = 1'b0;
  logic [7:0] m_a = '0;
  logic [2:0] m_s = '0;
  logic [7:0] m_base;

  initial for (int k = 0; k < 256; k++) mem[k] = 8'h00;

  always @(posedge clk) begin
    if (m_v && m_w)
      for (int j = 0; j < 4; j++)
        if (j < (1 << m_s))
          mem[8'(int'(m_a) + j)] <= hwdata[8*((int'(m_a) + j) % 4) +: 8];
    m_v <= htrans[1];
    m_w <= hwrite;
    m_a <= haddr[7:0];
    m_s <= hsize;
  end

  assign m_base = {m_a[7:2], 2'b00};
  assign hrdata = {mem[m_base + 8'd3], mem[m_base + 8'd2], mem[m_base + 8'd1], mem[m_base]};

  // Read data collector
  logic [DW-1:0] rd_got [32];
  int rd_cnt = 0;
  always @(negedge clk) if (rdat_valid) begin
    if (rd_cnt < 32) rd_got[rd_cnt] = rdat_data;
    rd_cnt++;
  end

  logic [7:0] shadow [256];
  initial for (int k = 0; k < 256; k++) shadow[k] = 8'h00;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int tag, input int i);
    return {8'(tag), 8'(i + 1), 8'(tag ^ 8'h5A), 8'(i * 7 + 3)};
  endfunction

  function automatic logic [2:0] exp_burst(input bit bst, input int n);
    if (!bst) return 3'b000;
    if (n == 4) return 3'b011;
    if (n == 8) return 3'b101;
    if (n == 16) return 3'b111;
    return 3'b001;
  endfunction

  task automatic do_xfer(input int addr, input bit wr, input bit bst,
                         input int beats, input int size, input int tag);
    int n;
    int s;
    n = bst ? ((beats == 0) ? 1 : beats) : 1;
    s = (size > 2) ? 2 : size;
    rd_cnt = 0;
    cmd_addr  = AW'(addr);
    cmd_write = wr;
    cmd_burst = bst;
    cmd_beats = BW'(beats);
    cmd_size  = 3'(size);
    cmd_valid = 1'b1;
    chk(cmd_ready == 1'b1, "R1", "ready before command", cmd_ready, 1);
    @(negedge clk);
    // R1: keep offering a different command while busy; it must be ignored
    cmd_addr  = AW'(addr + 64);
    cmd_write = ~wr;
    cmd_size  = 3'(size ^ 1);
    cmd_burst = ~bst;
    for (int i = 0; i < n; i++) begin
      chk(htrans == ((i == 0) ? 2'b10 : 2'b11), "R2", "htrans", htrans, (i == 0) ? 2 : 3);
      chk(haddr == AW'(addr + (i << s)), "R3", "haddr", haddr, addr + (i << s));
      chk(hsize == 3'(s), "R4", "hsize", hsize, s);
      chk(hburst == exp_burst(bst, n), "R5", "hburst", hburst, exp_burst(bst, n));
      chk(hwrite == wr, "R9", "hwrite", hwrite, wr);
      chk(cmd_ready == 1'b0, "R1", "ready while busy", cmd_ready, 0);
      chk(wdat_ready == wr, "R6", "wdat_ready", wdat_ready, wr);
      if (wr && i >= 1)
        chk(hwdata == pat(tag, i - 1), "R6", "hwdata", hwdata, pat(tag, i - 1));
      if (wr) begin
        wdat_valid = 1'b1;
        wdat_data  = pat(tag, i);
        for (int j = 0; j < (1 << s); j++) begin
          int b;
          b = addr + (i << s) + j;
          shadow[b & 255] = wdat_data[8*(b % 4) +: 8];
        end
      end
      @(negedge clk);
    end
    wdat_valid = 1'b0;
    cmd_valid  = 1'b0;
    chk(htrans == 2'b00, "R2", "idle after last beat", htrans, 0);
    chk(done == 1'b0, "R8", "done early", done, 0);
    chk(cmd_ready == 1'b0, "R1", "ready in last data phase", cmd_ready, 0);
    if (wr) chk(hwdata == pat(tag, n - 1), "R6", "last hwdata", hwdata, pat(tag, n - 1));
    @(negedge clk);
    chk(done == 1'b1, "R8", "done pulse", done, 1);
    chk(cmd_ready == 1'b1, "R8", "ready with done", cmd_ready, 1);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", done, 0);
    chk(rd_cnt == (wr ? 0 : n), "R7", "read beat count", rd_cnt, wr ? 0 : n);
    if (!wr)
      for (int i = 0; i < n && i < 32; i++) begin
        int base;
        logic [31:0] e;
        base = (addr + (i << s)) & 252;
        e = {shadow[base + 3], shadow[base + 2], shadow[base + 1], shadow[base]};
        chk(rd_got[i] == e, "R7", "read data", rd_got[i], e);
      end
  endtask

  initial begin
    int bl [8];
    int tag;
    bl = '{0, 1, 2, 3, 4, 5, 8, 16};
    tag = 1;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(htrans == 2'b00, "R10", "htrans in reset", htrans, 0);
    chk(cmd_ready == 1'b1, "R10", "cmd_ready in reset", cmd_ready, 1);
    chk(done == 1'b0, "R10", "done in reset", done, 0);
    chk(rdat_valid == 1'b0, "R10", "rdat_valid in reset", rdat_valid, 0);
    chk(wdat_ready == 1'b0, "R10", "wdat_ready in reset", wdat_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int sz = 0; sz < 4; sz++)
      for (int bi = 0; bi < 8; bi++)
        for (int bst = 0; bst < 2; bst++) begin
          int a;
          a = ((bi * 24 + sz * 8) & 127);
          do_xfer(a, 1'b1, bst[0], bl[bi], sz, tag);
          do_xfer(a, 1'b0, bst[0], bl[bi], sz, tag);
          tag++;
        end
    summary();
  end
endmodule